// File: doc/BRIEF.md
# Watchdog-Guarded Frequency Select Controller

This block decides which setting a programmable clock synthesizer should run at. It also protects every change of that setting with a watchdog. Software programs it through a plain register port: write strobe, write address, write data, plus a combinational read address and read data. Through this port software sets the mode bits, a 5-bit select code and two pairs of divider values, one for normal operation and one for recovery. The 5-bit strap pins are captured once, on the first clock after reset is released.

The outputs are:
- the active setting: a ratio code, a flag that says whether the divider pair is in use, and the divider pair itself;
- a one-cycle load strobe that tells the synthesizer to take the new setting;
- a system reset pulse;
- a recovery-lock flag.

With the watchdog enabled, the next accepted frequency change starts a countdown. If software does not disable the watchdog before the count runs out, the block pulses the system reset and applies the chosen recovery setting. It then rejects frequency writes until software clears the watchdog enable.

Register addresses:

| Address | Contents | Access |
|---|---|---|
| 0 | MODE: bit0 programmable mode, bit1 override | read/write |
| 1 | WDOG: bit0 enable, bit1 recovery source, bit7 time-out status | status is write-1-to-clear |
| 2 | SEL[4:0] | read/write |
| 3 | CPU N[7:0] | read/write |
| 4 | CPU M[6:0] | read/write |
| 5 | recovery N[7:0] | read/write |
| 6 | recovery M[6:0] | read/write |
| 7 | latched strap value | read-only |

Top module: `fsel_wdog_ctrl`

## Requirements
- R1: After reset, MODE reads 0, WDOG reads 0, the recovery lock is 0 and the system reset output is 0.
- R2: The strap pins are captured on the first clock after reset and read back at address 7. The first load strobe then presents that value as the ratio code, with the divider flag at 0 and N and M at 0.
- R3: With programmable mode 0, the ratio code is SEL when override is 1 and the strap value when override is 0. The divider flag is 0 and N and M read as 0.
- R4: With programmable mode 1, the divider flag is 1 and N and M are the CPU values. The ratio code is still SEL or the strap value, chosen by override.
- R5: An accepted write to address 0, 2, 3 or 4 (N or M alone is enough) raises the load strobe for exactly one cycle, two clocks after the write edge. The active outputs change in that same cycle and hold at every other time.
- R6: Setting the watchdog enable does not start the countdown by itself. Only a later load strobe does.
- R7: With the watchdog enabled, the system reset rises WDOG_CYC+1 cycles after a load strobe, stays high for RST_W cycles, and the lock rises together with it.
- R8: On time-out, recovery source 0 applies the strap value with the divider flag at 0. Recovery source 1 applies the recovery N and M with the divider flag at 1 and the ratio code chosen by override.
- R9: While locked, writes to addresses 0, 2, 3 and 4 change neither the register contents nor the outputs, and produce no load strobe.
- R10: Clearing the watchdog enable releases the lock. If a countdown is running, it is stopped, so no reset follows.
- R11: The status bit reads 1 after a time-out. Writing 1 to bit 7 clears it, and writing 0 leaves it unchanged.
- R12: The load strobe that applies the recovery setting comes one cycle after the system reset rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pins | input | 5 | Frequency strap pins, captured after reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| act_code | output | 5 | Active ratio code |
| act_use_nm | output | 1 | 1 when the divider pair sets the CPU frequency |
| act_n | output | 8 | Active N divider |
| act_m | output | 7 | Active M divider |
| load_stb | output | 1 | One-cycle load strobe for the synthesizer |
| sys_rst | output | 1 | System reset pulse |
| rcv_lock | output | 1 | Recovery lock flag |

## Verification
The bench builds the block with WDOG_CYC=40 and RST_W=5. At these values a full time-out, the reset pulse and the recovery load all happen within a few dozen cycles, so both recovery sources and the lock/unlock sequence fit in one short run. The time-out is short enough to measure exactly, from the strobe to the reset edge. The countdown is also short enough to be cancelled midway and then watched well past its expiry.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int FS_W   = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_WDOG = 3'd1,
    A_SEL  = 3'd2,
    A_CPUN = 3'd3,
    A_CPUM = 3'd4,
    A_RCVN = 3'd5,
    A_RCVM = 3'd6,
    A_FS   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic            prog;
    logic            ovr;
    logic            rcv_sel;
    logic            wd_en;
    logic            status;
    logic [FS_W-1:0] fs;
    logic [FS_W-1:0] sel;
    logic [N_W-1:0]  cpu_n;
    logic [M_W-1:0]  cpu_m;
    logic [N_W-1:0]  rcv_n;
    logic [M_W-1:0]  rcv_m;
  } cfg_t;

  typedef struct packed {
    logic [FS_W-1:0] code;
    logic            use_nm;
    logic [N_W-1:0]  n;
    logic [M_W-1:0]  m;
  } act_t;
endpackage

// File: rtl/fsel_regs.sv
module fsel_regs
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FS_W-1:0]   strap_pins,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              lock,
  input  logic              to_evt,
  output cfg_t              cfg,
  output logic              chg,
  output logic [DATA_W-1:0] rd_data
);
  cfg_t cfg_q, cfg_d;
  logic strap_done_q, strap_done_d;
  logic chg_q, chg_d;

  // next-state
  always_comb begin
    cfg_d        = cfg_q;
    strap_done_d = strap_done_q;
    chg_d        = 1'b0;
    if (!strap_done_q) begin
      cfg_d.fs     = strap_pins;
      strap_done_d = 1'b1;
      chg_d        = 1'b1;
    end
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_MODE: if (!lock) begin
          cfg_d.prog = wr_data[0];
          cfg_d.ovr  = wr_data[1];
          chg_d      = 1'b1;
        end
        A_WDOG: begin
          cfg_d.wd_en   = wr_data[0];
          cfg_d.rcv_sel = wr_data[1];
          if (wr_data[7]) cfg_d.status = 1'b0;
        end
        A_SEL: if (!lock) begin
          cfg_d.sel = wr_data[FS_W-1:0];
          chg_d     = 1'b1;
        end
        A_CPUN: if (!lock) begin
          cfg_d.cpu_n = wr_data[N_W-1:0];
          chg_d       = 1'b1;
        end
        A_CPUM: if (!lock) begin
          cfg_d.cpu_m = wr_data[M_W-1:0];
          chg_d       = 1'b1;
        end
        A_RCVN: cfg_d.rcv_n = wr_data[N_W-1:0];
        A_RCVM: cfg_d.rcv_m = wr_data[M_W-1:0];
        default: ;
      endcase
    end
    if (to_evt) cfg_d.status = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      strap_done_q <= 1'b0;
      chg_q        <= 1'b0;
    end else begin
      cfg_q        <= cfg_d;
      strap_done_q <= strap_done_d;
      chg_q        <= chg_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_MODE: rd_data = {6'b0, cfg_q.ovr, cfg_q.prog};
      A_WDOG: rd_data = {cfg_q.status, 5'b0, cfg_q.rcv_sel, cfg_q.wd_en};
      A_SEL:  rd_data = {{(DATA_W-FS_W){1'b0}}, cfg_q.sel};
      A_CPUN: rd_data = cfg_q.cpu_n;
      A_CPUM: rd_data = {{(DATA_W-M_W){1'b0}}, cfg_q.cpu_m};
      A_RCVN: rd_data = cfg_q.rcv_n;
      A_RCVM: rd_data = {{(DATA_W-M_W){1'b0}}, cfg_q.rcv_m};
      A_FS:   rd_data = {{(DATA_W-FS_W){1'b0}}, cfg_q.fs};
      default: rd_data = '0;
    endcase
  end

  assign cfg = cfg_q;
  assign chg = chg_q;

  AST_LOCK_BLOCKS_CHG: assert property (@(posedge clk) disable iff (!rst_n) // R9
    (lock && $past(lock)) |-> !chg_q);
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n) // R11
    to_evt |=> cfg_q.status);
endmodule

// File: rtl/fsel_select.sv
module fsel_select
  import fsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic chg,
  input  logic to_evt,
  output act_t act,
  output logic load_stb
);
  act_t act_q, act_d, norm_a, rcv_a;
  logic stb_q, stb_d;
  logic [FS_W-1:0] ratio;

  assign ratio = cfg.ovr ? cfg.sel : cfg.fs;

  always_comb begin
    norm_a.code = ratio;
    if (cfg.prog) begin
      norm_a.use_nm = 1'b1;
      norm_a.n      = cfg.cpu_n;
      norm_a.m      = cfg.cpu_m;
    end else begin
      norm_a.use_nm = 1'b0;
      norm_a.n      = '0;
      norm_a.m      = '0;
    end
    if (cfg.rcv_sel) begin
      rcv_a.code   = ratio;
      rcv_a.use_nm = 1'b1;
      rcv_a.n      = cfg.rcv_n;
      rcv_a.m      = cfg.rcv_m;
    end else begin
      rcv_a.code   = cfg.fs;
      rcv_a.use_nm = 1'b0;
      rcv_a.n      = '0;
      rcv_a.m      = '0;
    end
  end

  // next-state: recovery entry has priority over a normal change
  always_comb begin
    act_d = act_q;
    stb_d = 1'b0;
    if (to_evt) begin
      act_d = rcv_a;
      stb_d = 1'b1;
    end else if (chg) begin
      act_d = norm_a;
      stb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      stb_q <= 1'b0;
    end else begin
      act_q <= act_d;
      stb_q <= stb_d;
    end
  end

  assign act      = act_q;
  assign load_stb = stb_q;

  AST_RCV_STROBE: assert property (@(posedge clk) disable iff (!rst_n) // R12
    to_evt |=> stb_q);
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n) // R5
    !stb_q |-> $stable(act_q));
endmodule

// File: rtl/fsel_wdog.sv
module fsel_wdog #(
  parameter int WDOG_CYC = 1000000,
  parameter int RST_W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_en,
  input  logic load_stb,
  output logic lock,
  output logic to_evt,
  output logic sys_rst
);
  localparam int CW = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
  localparam int RW = $clog2(RST_W + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WDOG_CYC - 1);
  localparam logic [RW-1:0] RST_LOAD = RW'(RST_W);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;
  logic          to_q, to_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    lock_d = lock_q;
    to_d   = 1'b0;
    rcnt_d = (rcnt_q != '0) ? rcnt_q - 1'b1 : '0;
    if (!wd_en) begin
      run_d  = 1'b0;
      cnt_d  = CNT_LOAD;
      lock_d = 1'b0;
    end else if (load_stb && !lock_q) begin
      run_d = 1'b1;
      cnt_d = CNT_LOAD;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_d  = 1'b0;
        lock_d = 1'b1;
        to_d   = 1'b1;
        rcnt_d = RST_LOAD;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= CNT_LOAD;
      lock_q <= 1'b0;
      to_q   <= 1'b0;
      rcnt_q <= '0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
      to_q   <= to_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign lock    = lock_q;
  assign to_evt  = to_q;
  assign sys_rst = (rcnt_q != '0);

  AST_RST_WITH_LOCK: assert property (@(posedge clk) disable iff (!rst_n) // R7
    $rose(sys_rst) |-> $rose(lock_q));
  AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) // R7
    to_q |=> !to_q);
  AST_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) // R10
    !wd_en |=> (!run_q && !lock_q));
endmodule

// File: rtl/fsel_wdog_ctrl.sv
module fsel_wdog_ctrl
  import fsel_pkg::*;
#(
  parameter int WDOG_CYC = 1000000,
  parameter int RST_W    = 16,
  parameter int SYNC_N   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] strap_pins,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [4:0] act_code,
  output logic       act_use_nm,
  output logic [7:0] act_n,
  output logic [6:0] act_m,
  output logic       load_stb,
  output logic       sys_rst,
  output logic       rcv_lock
);
  logic [SYNC_N-1:0] rsync_q;
  logic rst_n_s;

  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q[i] <= 1'b0;
        else        rsync_q[i] <= (i == 0) ? 1'b1 : rsync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate
  assign rst_n_s = rsync_q[SYNC_N-1];

  cfg_t cfg;
  act_t act;
  logic chg, lock, to_evt;

  fsel_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .strap_pins(strap_pins),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .lock(lock), .to_evt(to_evt),
    .cfg(cfg), .chg(chg), .rd_data(rd_data)
  );

  fsel_select u_sel (
    .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .chg(chg),
    .to_evt(to_evt), .act(act), .load_stb(load_stb)
  );

  fsel_wdog #(.WDOG_CYC(WDOG_CYC), .RST_W(RST_W)) u_wdog (
    .clk(clk), .rst_n(rst_n_s), .wd_en(cfg.wd_en), .load_stb(load_stb),
    .lock(lock), .to_evt(to_evt), .sys_rst(sys_rst)
  );

  assign act_code   = act.code;
  assign act_use_nm = act.use_nm;
  assign act_n      = act.n;
  assign act_m      = act.m;
  assign rcv_lock   = lock;
endmodule

// File: tb/test_fsel_wdog_ctrl.sv
module test_fsel_wdog_ctrl;
  localparam int TO = 40;
  localparam int RW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] strap_pins = 5'h13;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [4:0] act_code;
  logic act_use_nm, load_stb, sys_rst, rcv_lock;
  logic [7:0] act_n;
  logic [6:0] act_m;

  always #4 clk = ~clk;

  fsel_wdog_ctrl #(.WDOG_CYC(TO), .RST_W(RW)) i_fsel_wdog_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .act_code(act_code), .act_use_nm(act_use_nm), .act_n(act_n), .act_m(act_m),
    .load_stb(load_stb), .sys_rst(sys_rst), .rcv_lock(rcv_lock)
  );

  typedef struct packed {
    logic [4:0] code; logic nm; logic [7:0] n; logic [6:0] m;
  } exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0;
  int cyc = 0, rises = 0, rise_cyc = 0, stb_last = 0, stb_at_rise = 0;
  int hi_cnt = 0, last_width = 0;
  logic rst_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic push(input logic [4:0] c, input logic nm, input logic [7:0] n, input logic [6:0] m);
    exp_t e;
    e.code = c; e.nm = nm; e.n = n; e.m = m;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: scoreboard pop on every strobe, reset pulse measurement
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (load_stb) begin
        stb_last = cyc;
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected load strobe", {act_code, act_use_nm, act_n, act_m}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({act_code, act_use_nm, act_n, act_m} == e, "R3/R4/R8 active setting at strobe",
              {act_code, act_use_nm, act_n, act_m}, e);
        end
      end
      if (sys_rst && !rst_prev) begin
        rises++; rise_cyc = cyc; stb_at_rise = stb_last; hi_cnt = 0;
      end
      if (sys_rst) hi_cnt++;
      if (!sys_rst && rst_prev) last_width = hi_cnt;
      rst_prev = sys_rst;
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] d;
    push(5'h13, 1'b0, 8'h00, 7'h00); // R2 start-up load
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(10);
    rd(3'd0, d); chk(d == 8'h00, "R1 MODE reset", d, 0);
    rd(3'd1, d); chk(d == 8'h00, "R1 WDOG reset", d, 0);
    chk(rcv_lock == 1'b0 && sys_rst == 1'b0, "R1 lock/reset idle", {rcv_lock, sys_rst}, 0);
    rd(3'd7, d); chk(d == 8'h13, "R2 strap readback", d, 8'h13);
    chk(act_code == 5'h13 && !act_use_nm, "R2 initial code", act_code, 5'h13);

    // R3
    push(5'h13, 1'b0, 8'h00, 7'h00); wr(3'd2, 8'h0A);
    push(5'h0A, 1'b0, 8'h00, 7'h00); wr(3'd0, 8'h02);
    wait_cyc(2);
    chk(act_code == 5'h0A, "R3 override selects SEL", act_code, 5'h0A);
    // R4
    push(5'h0A, 1'b0, 8'h00, 7'h00); wr(3'd3, 8'h55);
    push(5'h0A, 1'b1, 8'h55, 7'h00); wr(3'd0, 8'h03);
    // R5: M alone, strobe two clocks after the write edge, outputs same cycle
    push(5'h0A, 1'b1, 8'h55, 7'h21); wr(3'd4, 8'h21);
    chk(load_stb == 1'b0, "R5 strobe not early", load_stb, 0);
    @(negedge clk);
    chk(load_stb == 1'b1 && act_m == 7'h21, "R5 strobe with new M", {load_stb, act_m}, {1'b1, 7'h21});
    @(negedge clk);
    chk(load_stb == 1'b0, "R5 strobe one cycle", load_stb, 0);
    push(5'h13, 1'b1, 8'h55, 7'h21); wr(3'd0, 8'h01);
    wait_cyc(2);
    chk(act_code == 5'h13 && act_use_nm, "R4 ratio from strap", act_code, 5'h13);

    // R6: enable alone does not count down
    wr(3'd1, 8'h01);
    wait_cyc(TO + 20);
    chk(rises == 0, "R6 no reset without change", rises, 0);

    // R7/R8/R12: time-out, recovery from strap
    push(5'h13, 1'b1, 8'h60, 7'h21);
    push(5'h13, 1'b0, 8'h00, 7'h00);
    wr(3'd3, 8'h60);
    for (int i = 0; i < 3 * TO && rises == 0; i++) @(negedge clk);
    wait_cyc(RW + 5);
    chk(rises == 1, "R7 reset occurred", rises, 1);
    chk(rise_cyc - stb_at_rise == TO + 1, "R7 time-out length", rise_cyc - stb_at_rise, TO + 1);
    chk(last_width == RW, "R7 reset width", last_width, RW);
    chk(stb_last == rise_cyc + 1, "R12 recovery strobe timing", stb_last - rise_cyc, 1);
    chk(rcv_lock == 1'b1, "R7 lock set", rcv_lock, 1);
    chk(act_code == 5'h13 && !act_use_nm, "R8 strap recovery", {act_code, act_use_nm}, {5'h13, 1'b0});
    rd(3'd1, d); chk(d == 8'h81, "R11 status after time-out", d, 8'h81);

    // R9: locked writes ignored
    wr(3'd3, 8'h11); wr(3'd0, 8'h00); wr(3'd2, 8'h1F);
    wait_cyc(3);
    rd(3'd3, d); chk(d == 8'h60, "R9 CPU N unchanged", d, 8'h60);
    rd(3'd0, d); chk(d == 8'h01, "R9 MODE unchanged", d, 8'h01);
    rd(3'd2, d); chk(d == 8'h0A, "R9 SEL unchanged", d, 8'h0A);
    chk(act_code == 5'h13 && !act_use_nm, "R9 outputs unchanged", act_code, 5'h13);

    // R11: write 0 keeps, write 1 clears
    wr(3'd1, 8'h01);
    rd(3'd1, d); chk(d == 8'h81, "R11 write 0 no effect", d, 8'h81);
    wr(3'd1, 8'h81);
    rd(3'd1, d); chk(d == 8'h01, "R11 write 1 clears", d, 8'h01);
    chk(rcv_lock == 1'b1, "R10 lock held while enabled", rcv_lock, 1);
    // R10: clear enable unlocks
    wr(3'd1, 8'h00);
    @(negedge clk);
    chk(rcv_lock == 1'b0, "R10 lock released", rcv_lock, 0);

    // R8 source 1
    wr(3'd5, 8'h44); wr(3'd6, 8'h12);
    wr(3'd1, 8'h03);
    push(5'h13, 1'b1, 8'h60, 7'h30);
    push(5'h13, 1'b1, 8'h44, 7'h12);
    wr(3'd4, 8'h30);
    for (int i = 0; i < 3 * TO && rises == 1; i++) @(negedge clk);
    wait_cyc(RW + 5);
    chk(rises == 2, "R7 second reset", rises, 2);
    chk(act_use_nm && act_n == 8'h44 && act_m == 7'h12, "R8 divider recovery",
        {act_use_nm, act_n, act_m}, {1'b1, 8'h44, 7'h12});

    // R10: stop mid-countdown
    wr(3'd1, 8'h80);
    wr(3'd1, 8'h01);
    push(5'h13, 1'b1, 8'h60, 7'h30); wr(3'd2, 8'h05);
    wait_cyc(TO / 2);
    wr(3'd1, 8'h00);
    wait_cyc(TO + 10);
    chk(rises == 2, "R10 stopped countdown", rises, 2);
    chk(q.size() == 0, "R5 all expected loads seen", q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule